// File: doc/BRIEF.md
# Dynamic Pixel-Pair Hit Formatter

The block takes triggered single-pixel hits and packs them into fixed 24-bit records. Each input beat carries a hit word protected by a single-error-correcting, double-error-detecting code, or it carries an end-of-event marker instead. The beat is decoded and corrected first. Hits arrive sorted by column and, within a column, by rising row.

A valid hit is held for one input beat. If the next accepted hit lies in the same column, one row above, the two are packed into one record. Otherwise the held hit goes out alone, with its partner slot marked empty. The pair's base row is taken from whichever hit came first, so pairs may begin on odd or even rows.

Beats that the code cannot repair are dropped and reported on a separate error pulse. Output back-pressure stalls the input, and no held hit is lost.

Top module: `dyn_pair_fmt`

## Requirements
- R1: While reset is asserted and after it is released, out_valid_o and err_o are 0 and in_ready_o is 1.
- R2: A record has this layout: [23:17] column, [16:8] base row, [7:4] base ToT, [3:0] partner ToT. A partner ToT of 4'hF means that no partner is present.
- R3: If a hit is held at (c, r) and the next accepted valid hit is at (c, r+1), both are emitted as one record with partner ToT set to the second hit's ToT, and no hit stays held.
- R4: Pairing does not follow a fixed row grid. The base row of a pair may be odd or even.
- R5: If the next accepted valid hit is not at (c, r+1), the held hit is emitted alone with partner 4'hF, and the new hit becomes the held hit.
- R6: A hit in a different column flushes the held hit as a lone record, whatever rows the two hits have.
- R7: An accepted end-of-event beat (in_eoe_i=1) flushes a held hit as a lone record and leaves nothing held. With nothing held, the beat emits no record. Its code word is ignored.
- R8: A hit that has just completed a pair is never paired again. The next hit at its row plus one starts a new record.
- R9: Code word layout: positions 1..25 form a Hamming code with check bits at positions 1, 2, 4, 8 and 16. The 20 data bits {column[6:0], row[8:0], tot[3:0]} go, LSB first, into the other positions in ascending order. Bit 0 holds the even parity of bits 25..1. Any single flipped bit is corrected.
- R10: A hit beat with two flipped bits is dropped. err_o is 1 for exactly the cycle after that beat is accepted. The held hit is not changed, so a pair can still form across the dropped beat.
- R11: in_ready_o = !out_valid_o || out_ready_i. While out_valid_o=1 and out_ready_i=0, out_data_o stays stable.
- R12: A record becomes valid in the cycle after the beat that completes it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| in_eoe_i | input | 1 | Beat is an end-of-event marker |
| in_code_i | input | 26 | Protected hit word |
| out_valid_o | output | 1 | Record valid |
| out_ready_i | input | 1 | Downstream accepts record |
| out_data_o | output | 24 | Packed record |
| err_o | output | 1 | Uncorrectable hit dropped (one-cycle pulse) |

## Verification
Two situations can land in the same cycle. In the first, a beat that flushes the held hit arrives while the previous record is still stalled at the output. In the second, an uncorrectable beat arrives while a hit is held and a record is waiting. Both are provoked by a long random run with pseudo-random back-pressure, scattered single-bit and double-bit flips and end-of-event markers, on top of directed sequences. A behavioural model predicts, for every clock, out_valid_o, in_ready_o and err_o, and it predicts each record's contents when the record is transferred.

// File: rtl/dyn_pair_fmt_pkg.sv
package dyn_pair_fmt_pkg;
  localparam int COL_W = 7;
  localparam int ROW_W = 9;
  localparam int TOT_W = 4;
  localparam int HIT_W = COL_W + ROW_W + TOT_W;
  localparam int REC_W = COL_W + ROW_W + 2 * TOT_W;
  localparam logic [TOT_W-1:0] TOT_NONE = '1;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [TOT_W-1:0] tot;
  } hit_t;

  function automatic int par_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int PAR_W  = par_bits(HIT_W);
  localparam int CODE_W = HIT_W + PAR_W + 1;
endpackage

// File: rtl/pair_fmt_secded.sv
module pair_fmt_secded
  import dyn_pair_fmt_pkg::*;
#(
  parameter int DATA_W = HIT_W,
  parameter int PW     = par_bits(DATA_W)
) (
  input  logic [DATA_W+PW:0]  code_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                fatal_o
);
  localparam int HAM_N  = DATA_W + PW;
  localparam int CODE_N = HAM_N + 1;

  logic [PW-1:0]     syn;
  logic              ovr;
  logic [CODE_N-1:0] fixed;

  function automatic logic [PW-1:0] syndrome(input logic [CODE_N-1:0] c);
    logic [PW-1:0] s;
    s = '0;
    for (int p = 1; p <= HAM_N; p++)
      if (c[p]) s ^= PW'(p);
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [CODE_N-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction

  always_comb begin
    syn     = syndrome(code_i);
    ovr     = ^code_i;
    fixed   = code_i;
    fatal_o = 1'b0;
    if (ovr) begin
      // odd weight: single flip at position syn (0 = overall bit)
      if (int'(syn) <= HAM_N) fixed[syn] = ~fixed[syn];
      else fatal_o = 1'b1;
    end else if (syn != '0) begin
      fatal_o = 1'b1;
    end
    data_o = extract(fixed);
  end
endmodule

// File: rtl/pair_fmt_merge.sv
module pair_fmt_merge
  import dyn_pair_fmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_eoe_i,
  input  logic             in_fatal_i,
  input  hit_t             in_hit_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [REC_W-1:0] out_data_o,
  input  logic             out_ready_i,
  output logic             err_o
);
  logic             held_q;
  hit_t             held_hit_q;
  logic             out_valid_q;
  logic [REC_W-1:0] out_data_q;
  logic             err_q;

  logic             accept, take_hit, take_eoe, take_bad, adjacent, emit;
  logic [ROW_W:0]   row_next;
  logic [REC_W-1:0] rec;

  assign in_ready_o  = !out_valid_q || out_ready_i;
  assign accept      = in_valid_i && in_ready_o;
  assign take_eoe    = accept && in_eoe_i;
  assign take_bad    = accept && !in_eoe_i && in_fatal_i;
  assign take_hit    = accept && !in_eoe_i && !in_fatal_i;
  assign row_next    = {1'b0, held_hit_q.row} + (ROW_W+1)'(1);
  assign adjacent    = held_q && (in_hit_i.col == held_hit_q.col) &&
                       ({1'b0, in_hit_i.row} == row_next);

  always_comb begin
    emit = 1'b0;
    rec  = {held_hit_q.col, held_hit_q.row, held_hit_q.tot, TOT_NONE};
    if (take_hit && adjacent) begin
      emit = 1'b1;
      rec  = {held_hit_q.col, held_hit_q.row, held_hit_q.tot, in_hit_i.tot};
    end else if ((take_hit || take_eoe) && held_q) begin
      emit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q      <= 1'b0;
      held_hit_q  <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= take_bad;
      if (take_eoe) begin
        held_q <= 1'b0;
      end else if (take_hit) begin
        held_q <= !adjacent;
        if (!adjacent) held_hit_q <= in_hit_i;
      end
      if (emit) begin
        out_valid_q <= 1'b1;
        out_data_q  <= rec;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;
  assign err_o       = err_q;

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R12
  rec_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));
  // R10
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(in_valid_i && in_ready_o && !in_eoe_i));
  // R10
  bad_keeps_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_bad |=> $stable(held_q) && $stable(held_hit_q));
  // R7
  eoe_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_eoe |=> !held_q);
endmodule

// File: rtl/dyn_pair_fmt.sv
module dyn_pair_fmt
  import dyn_pair_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_eoe_i,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [REC_W-1:0]  out_data_o,
  output logic              err_o
);
  logic [HIT_W-1:0] dec_data;
  logic             dec_fatal;
  hit_t             dec_hit;

  pair_fmt_secded #(.DATA_W(HIT_W), .PW(PAR_W)) u_dec (
    .code_i  (in_code_i),
    .data_o  (dec_data),
    .fatal_o (dec_fatal)
  );

  assign dec_hit = hit_t'(dec_data);

  pair_fmt_merge u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_eoe_i    (in_eoe_i),
    .in_fatal_i  (dec_fatal),
    .in_hit_i    (dec_hit),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .err_o       (err_o)
  );
endmodule

// File: tb/dyn_pair_fmt_tb.sv
module dyn_pair_fmt_tb;
  import dyn_pair_fmt_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_eoe_i = 1'b0;
  logic [CODE_W-1:0] in_code_i = '0;
  logic              out_ready_i = 1'b1;
  logic              in_ready_o, out_valid_o, err_o;
  logic [REC_W-1:0]  out_data_o;

  always #2 clk = ~clk;

  dyn_pair_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_eoe_i(in_eoe_i), .in_code_i(in_code_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .err_o(err_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [REC_W-1:0] expq[$];
  bit exp_ov = 0, err_pend = 0, bp_on = 0;
  bit held_v = 0;
  int held_c, held_r, held_t;
  bit b_eoe, b_bad;
  int b_col, b_row, b_tot;
  int unsigned rng = 32'h1234_5678;

  function automatic int unsigned rnd();
    rng = rng * 1103515245 + 12345;
    return rng >> 8;
  endfunction

  function automatic logic [REC_W-1:0] pack(int c, int r, int t0, int t1);
    return {7'(c), 9'(r), 4'(t0), 4'(t1)};
  endfunction

  function automatic logic [CODE_W-1:0] enc(int c, int r, int t);
    logic [HIT_W-1:0]  d;
    logic [CODE_W-1:0] w;
    int k;
    bit x;
    d = {7'(c), 9'(r), 4'(t)};
    w = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++)
      if ((p & (p - 1)) != 0) begin w[p] = d[k]; k++; end
    for (int i = 0; i < PAR_W; i++) begin
      x = 0;
      for (int p = 1; p < CODE_W; p++)
        if ((p & (1 << i)) != 0 && p != (1 << i)) x ^= w[p];
      w[1 << i] = x;
    end
    w[0] = ^w[CODE_W-1:1];
    return w;
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic step(output bit acc);
    bit emit;
    logic [REC_W-1:0] e;
    #1;
    chk(out_valid_o == exp_ov, $sformatf("%s/R12 out_valid act=%0b exp=%0b", cur_req, out_valid_o, exp_ov));
    chk(in_ready_o == (!exp_ov || out_ready_i),
        $sformatf("%s/R11 in_ready act=%0b exp=%0b", cur_req, in_ready_o, !exp_ov || out_ready_i));
    chk(err_o == err_pend, $sformatf("%s/R10 err act=%0b exp=%0b", cur_req, err_o, err_pend));
    if (out_valid_o && out_ready_i) begin
      if (expq.size() == 0) chk(0, $sformatf("%s/R2 record act=%h exp=none", cur_req, out_data_o));
      else begin
        e = expq.pop_front();
        chk(out_data_o == e, $sformatf("%s/R2 record act=%h exp=%h", cur_req, out_data_o, e));
      end
    end
    acc = in_valid_i && in_ready_o;
    emit = 0;
    err_pend = 0;
    if (acc) begin
      if (b_eoe) begin
        if (held_v) begin expq.push_back(pack(held_c, held_r, held_t, 15)); emit = 1; end
        held_v = 0;
      end else if (b_bad) begin
        err_pend = 1;
      end else if (held_v && b_col == held_c && b_row == held_r + 1) begin
        expq.push_back(pack(held_c, held_r, held_t, b_tot));
        emit = 1;
        held_v = 0;
      end else begin
        if (held_v) begin expq.push_back(pack(held_c, held_r, held_t, 15)); emit = 1; end
        held_v = 1; held_c = b_col; held_r = b_row; held_t = b_tot;
      end
    end
    exp_ov = emit ? 1'b1 : (exp_ov && !out_ready_i);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ready();
    out_ready_i = bp_on ? rnd() % 3 != 0 : 1'b1;
  endtask

  task automatic send(input bit eoe, input int c, input int r, input int t,
                      input logic [CODE_W-1:0] flip);
    bit acc;
    in_valid_i = 1; in_eoe_i = eoe;
    in_code_i = enc(c, r, t) ^ flip;
    b_eoe = eoe; b_col = c; b_row = r; b_tot = t;
    b_bad = !eoe && $countones(flip) == 2;
    do begin set_ready(); step(acc); end while (!acc);
    in_valid_i = 0;
  endtask

  task automatic hit(input int c, input int r, input int t);
    send(0, c, r, t, '0);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin set_ready(); step(acc); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!out_valid_o && !err_o && in_ready_o, "R1 reset outputs act!=exp (0,0,1)");
    rst_ni = 1;
    @(negedge clk);
    chk(!out_valid_o && !err_o && in_ready_o, "R1 after reset outputs act!=exp (0,0,1)");

    cur_req = "R3"; hit(3, 10, 4); hit(3, 11, 7); idle(2);
    cur_req = "R5"; hit(3, 20, 2); hit(3, 22, 9);
    cur_req = "R6"; hit(4, 0, 1);
    cur_req = "R4"; hit(4, 1, 3); hit(4, 5, 6); hit(4, 6, 8);
    cur_req = "R8"; hit(4, 7, 1); hit(4, 8, 2); hit(4, 9, 5);
    cur_req = "R7"; send(1, 0, 0, 0, '0); send(1, 0, 0, 0, '0); idle(2);
    cur_req = "R6"; hit(5, 100, 4); hit(6, 101, 4); send(1, 0, 0, 0, '0); idle(2);
    cur_req = "R9";
    for (int b = 0; b < CODE_W; b++) begin
      send(0, 10 + b, 2 * b + 1, b % 15, CODE_W'(1) << b);
    end
    send(1, 0, 0, 0, '0); idle(2);
    cur_req = "R10"; hit(40, 30, 3); send(0, 40, 77, 2, CODE_W'(6)); hit(40, 31, 12);
    send(0, 41, 5, 5, (CODE_W'(1) << 25) | CODE_W'(1)); send(1, 0, 0, 0, '0); idle(2);
    cur_req = "R2"; hit(79, 334, 14); hit(79, 335, 0); hit(79, 335, 5); hit(80 - 1, 335, 5);
    send(1, 0, 0, 0, '0); idle(2);
    cur_req = "R11"; bp_on = 1;
    begin
      int c, r, x;
      c = 0; r = 0;
      for (int i = 0; i < 400; i++) begin
        x = rnd() % 16;
        if (x == 0) send(1, 0, 0, 0, '0);
        else if (x == 1) send(0, c, r + 1, rnd() % 15, CODE_W'(5) << (rnd() % 20));
        else begin
          r = r + 1 + (x % 3);
          if (r > 335 || x == 15) begin c = (c + 1) % 80; r = rnd() % 4; end
          send(0, c, r, rnd() % 15, (x == 2) ? CODE_W'(1) << (rnd() % CODE_W) : '0);
        end
      end
    end
    send(1, 0, 0, 0, '0);
    bp_on = 0; idle(4);
    chk(expq.size() == 0, $sformatf("R12 pending records act=%0d exp=0", expq.size()));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule